// File: doc/BRIEF.md
# Two-Stage Expiry Watchdog with APB Register Port

This peripheral guards a processor against lock-up with a 32-bit down-counter that decrements once for every cycle in which a single-cycle count-enable input is high. When the count first runs out, the block raises a raw interrupt flag and starts counting again from the reload value. Software is expected to service the interrupt by writing the clear register, which drops the flag and restarts the count. If the count runs out a second time while the flag is still set, the block latches a reset request and the counter freezes at zero.

Software reaches the block through an APB completer port that never inserts wait states. The two outputs, interrupt and reset request, each have their own enable bit. A key-protected lock discards register writes made by mistake. An integration-test mode lets a register drive both output pins directly. A build-time variant makes the interrupt enable sticky: once it is set, only a reset can change the control register. The same variant removes the test registers.

Top module: `wdt_apb2stage`

## Requirements
- R1: After reset, load (0x000) and value (0x004) read 0xFFFFFFFF, control (0x008) and lock (0xC00) read 0, the counter is running, and both outputs are low.
- R2: Every APB transfer completes in its access phase with pready high and pslverr low.
- R3: Control bit 0 is the interrupt enable and bit 1 is the reset enable. Written values are masked to these two bits, so a control write of 0xFFFFFFFF reads back 0x3.
- R4: Writing 0x1ACCE551 to the lock register at 0xC00 clears the lock, and writing any other value there sets it. The lock register reads 1 when locked. While locked, writes to every other offset are discarded.
- R5: A write to the load register stores the reload value, copies it into the counter in the same cycle, and restarts counting if counting had stopped.
- R6: The counter decrements by one on each cycle with tick_en high. A decrement from 1 to 0 is an expiry. When the raw flag (bit 0 at 0x010) is clear, an expiry sets it. The tick after an expiry reloads the counter from the load value. With load value L, the first expiry therefore falls on tick L.
- R7: An expiry while the raw flag is already set latches the reset status and stops the counter at 0. With load value L and no servicing, this happens on tick 2L+1.
- R8: Any write to the clear register at 0x00C clears the raw flag and reloads the counter from the load value. A load or clear write takes precedence over a tick in the same cycle.
- R9: irq_o is the raw flag ANDed with control bit 0. rst_req_o is the reset status ANDed with control bit 1. The masked status at 0x014 reads the gated interrupt.
- R10: When bit 0 of the test control register (0xF00) is set, rst_req_o follows bit 0 of the test output register (0xF04) and irq_o follows bit 1 of it.
- R11: Reads of 0x00C, 0xF04 and unmapped offsets return 0. Writes to 0x004, 0x010, 0x014 and the ID words at 0xFD0 to 0xFFC are ignored. The ID words read 0x21 at 0xFE0 and 0x0D at 0xFF0.
- R12: With STICKY_IRQ_EN=1, control writes are ignored once control bit 0 is set. The test registers are then unmapped: they read 0 and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and the counter |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| tick_en | input | 1 | One-cycle count enable |
| irq_o | output | 1 | Interrupt output |
| rst_req_o | output | 1 | Reset request output |

## Verification
The bench sweeps load values 1 to 8. For each value it counts ticks to the first and second expiry, which catches an off-by-one in the 1-to-0 detection or in the reload tick: such a design fires one tick early or late. It checks that the value register stays at zero after the reset request. A design that keeps counting after the second expiry would show a nonzero or wrapped value there. It sweeps all four control settings and all four test-output patterns against the outputs, which catches swapped enables or swapped test bits. It also checks that servicing the interrupt holds off the reset request, that locked writes are dropped, and that the sticky enable in the variant cannot be changed once set.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int AW = 12;
  localparam logic [AW-1:0] OFS_LOAD  = 12'h000;
  localparam logic [AW-1:0] OFS_VALUE = 12'h004;
  localparam logic [AW-1:0] OFS_CTRL  = 12'h008;
  localparam logic [AW-1:0] OFS_CLR   = 12'h00C;
  localparam logic [AW-1:0] OFS_RAW   = 12'h010;
  localparam logic [AW-1:0] OFS_MASK  = 12'h014;
  localparam logic [AW-1:0] OFS_LOCK  = 12'hC00;
  localparam logic [AW-1:0] OFS_TCTL  = 12'hF00;
  localparam logic [AW-1:0] OFS_TOUT  = 12'hF04;
  localparam logic [AW-1:0] OFS_ID_LO = 12'hFD0;
  localparam logic [AW-1:0] OFS_ID_HI = 12'hFFC;
  localparam logic [31:0]   UNLOCK_KEY = 32'h1ACC_E551;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DW = 32,
  parameter bit STICKY_IRQ_EN = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [1:0]    ctrl,
  output logic          locked,
  output logic          test_en,
  output logic [1:0]    test_out,
  output logic [DW-1:0] load_q,
  output logic          load_wr,
  output logic          clr_wr
);
  logic wr_ok;
  logic ctrl_open;

  assign wr_ok   = wr_en && (!locked || addr == OFS_LOCK);
  assign load_wr = wr_ok && addr == OFS_LOAD;
  assign clr_wr  = wr_ok && addr == OFS_CLR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      load_q <= '1;
      ctrl   <= '0;
    end else begin
      if (wr_en && addr == OFS_LOCK) locked <= (wdata != UNLOCK_KEY);
      if (load_wr) load_q <= wdata;
      if (wr_ok && addr == OFS_CTRL && ctrl_open) ctrl <= wdata[1:0];
    end
  end

  generate
    if (STICKY_IRQ_EN) begin : g_sticky
      assign ctrl_open = !ctrl[0];
      assign test_en   = 1'b0;
      assign test_out  = 2'b00;
    end else begin : g_plain
      logic       ten_q;
      logic [1:0] tout_q;
      assign ctrl_open = 1'b1;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ten_q  <= 1'b0;
          tout_q <= 2'b00;
        end else begin
          if (wr_ok && addr == OFS_TCTL) ten_q  <= wdata[0];
          if (wr_ok && addr == OFS_TOUT) tout_q <= wdata[1:0];
        end
      end
      assign test_en  = ten_q;
      assign test_out = tout_q;
    end
  endgenerate
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          load_wr,
  input  logic          clr_wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] load_q,
  output logic [DW-1:0] cnt,
  output logic          run,
  output logic          raw,
  output logic          rst_st
);
  localparam logic [DW-1:0] ONE = DW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '1;
      run    <= 1'b1;
      raw    <= 1'b0;
      rst_st <= 1'b0;
    end else if (load_wr) begin
      cnt <= wdata;
      run <= 1'b1;
    end else if (clr_wr) begin
      cnt <= load_q;
      raw <= 1'b0;
    end else if (run && tick_en) begin
      if (cnt == ONE) begin
        cnt <= '0;
        if (raw) begin
          rst_st <= 1'b1;
          run    <= 1'b0;
        end else begin
          raw <= 1'b1;
        end
      end else if (cnt == '0) begin
        cnt <= load_q;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end
endmodule

// File: rtl/wdt_readmux.sv
module wdt_readmux
  import wdt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] load_q,
  input  logic [DW-1:0] cnt,
  input  logic [1:0]    ctrl,
  input  logic          raw,
  input  logic          locked,
  input  logic          test_en,
  output logic [DW-1:0] rdata
);
  logic [3:0] id_idx;
  logic [7:0] id_byte;

  assign id_idx = 4'((addr - OFS_ID_LO) >> 2);

  always_comb begin
    case (id_idx)
      4'd4:    id_byte = 8'h21;
      4'd5:    id_byte = 8'h43;
      4'd6:    id_byte = 8'h0B;
      4'd8:    id_byte = 8'h0D;
      4'd9:    id_byte = 8'hF0;
      4'd10:   id_byte = 8'h05;
      4'd11:   id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_LOAD:  rdata = load_q;
      OFS_VALUE: rdata = cnt;
      OFS_CTRL:  rdata = DW'(ctrl);
      OFS_RAW:   rdata = DW'(raw);
      OFS_MASK:  rdata = DW'(raw & ctrl[0]);
      OFS_LOCK:  rdata = DW'(locked);
      OFS_TCTL:  rdata = DW'(test_en);
      default: begin
        if (addr >= OFS_ID_LO && addr <= OFS_ID_HI && addr[1:0] == 2'b00)
          rdata = DW'(id_byte);
      end
    endcase
  end
endmodule

// File: rtl/wdt_apb2stage.sv
module wdt_apb2stage
  import wdt_pkg::*;
#(
  parameter int DW = 32,
  parameter bit STICKY_IRQ_EN = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [11:0]   paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          pready,
  output logic          pslverr,
  input  logic          tick_en,
  output logic          irq_o,
  output logic          rst_req_o
);
  logic          wr_en;
  logic [1:0]    ctrl;
  logic          locked, test_en, load_wr, clr_wr;
  logic [1:0]    test_out;
  logic [DW-1:0] load_q, cnt;
  logic          run, raw, rst_st;

  assign wr_en   = psel && penable && pwrite;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  wdt_regs #(.DW(DW), .STICKY_IRQ_EN(STICKY_IRQ_EN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(paddr), .wdata(pwdata),
    .ctrl(ctrl), .locked(locked), .test_en(test_en), .test_out(test_out),
    .load_q(load_q), .load_wr(load_wr), .clr_wr(clr_wr)
  );

  wdt_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_wr(load_wr),
    .clr_wr(clr_wr), .wdata(pwdata), .load_q(load_q), .cnt(cnt),
    .run(run), .raw(raw), .rst_st(rst_st)
  );

  wdt_readmux #(.DW(DW)) u_rd (
    .addr(paddr), .load_q(load_q), .cnt(cnt), .ctrl(ctrl), .raw(raw),
    .locked(locked), .test_en(test_en), .rdata(prdata)
  );

  assign irq_o     = test_en ? test_out[1] : (raw & ctrl[0]);
  assign rst_req_o = test_en ? test_out[0] : (rst_st & ctrl[1]);
endmodule

// File: rtl/wdt_apb2stage_chk.sv
module wdt_apb2stage_chk
  import wdt_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [11:0] paddr,
  input logic        pready,
  input logic        pslverr,
  input logic        tick_en,
  input logic        locked,
  input logic [31:0] load_q,
  input logic [1:0]  ctrl,
  input logic        load_wr,
  input logic        clr_wr,
  input logic [31:0] cnt,
  input logic        run,
  input logic        raw,
  input logic        rst_st
);
  a_r2_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr);

  a_r4_locked_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && locked && paddr != OFS_LOCK)
      |=> ($stable(load_q) && $stable(ctrl)));

  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_en && cnt > 32'd1 && !load_wr && !clr_wr)
      |=> (cnt == $past(cnt) - 32'd1));

  a_r6_raw_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw) |-> $past(tick_en));

  a_r7_second_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_st) |-> $past(raw));

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_wr && !clr_wr) |=> $stable(cnt));
endmodule

bind wdt_apb2stage wdt_apb2stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pready(pready), .pslverr(pslverr), .tick_en(tick_en),
  .locked(locked), .load_q(load_q), .ctrl(ctrl), .load_wr(load_wr),
  .clr_wr(clr_wr), .cnt(cnt), .run(run), .raw(raw), .rst_st(rst_st)
);

// File: tb/wdt_apb2stage_tb_top.sv
module wdt_apb2stage_tb_top;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0, tick_en = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, prdata_v, rd;
  logic pready, pslverr, irq, rreq, pready_v, pslverr_v, irq_v, rreq_v;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  wdt_apb2stage dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .tick_en(tick_en), .irq_o(irq), .rst_req_o(rreq)
  );

  wdt_apb2stage #(.STICKY_IRQ_EN(1'b1)) dut_v (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata_v), .pready(pready_v),
    .pslverr(pslverr_v), .tick_en(tick_en), .irq_o(irq_v), .rst_req_o(rreq_v)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rdreg(input logic [11:0] a, output logic [31:0] d, output logic [31:0] dv);
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk);
    penable = 1;
    #1;
    d = prdata; dv = prdata_v;
    check("R2 pready", {31'b0, pready}, 32'd1);
    check("R2 pslverr", {31'b0, pslverr}, 32'd0);
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic tick1();
    @(negedge clk);
    tick_en = 1;
    @(negedge clk);
    tick_en = 0;
  endtask

  logic [31:0] rv;
  int n;

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    rdreg(12'h000, rd, rv); check("R1 load", rd, 32'hFFFF_FFFF);
    rdreg(12'h004, rd, rv); check("R1 value", rd, 32'hFFFF_FFFF);
    rdreg(12'h008, rd, rv); check("R1 ctrl", rd, 0);
    rdreg(12'hC00, rd, rv); check("R1 lock", rd, 0);
    check("R1 outs", {30'b0, irq, rreq}, 0);
    tick1();
    rdreg(12'h004, rd, rv); check("R1 running", rd, 32'hFFFF_FFFE);

    // R3 mask
    wr(12'h008, 32'hFFFF_FFFF);
    rdreg(12'h008, rd, rv); check("R3 ctrl mask", rd, 32'h3);

    // R11 read-only/unmapped/ID
    wr(12'h004, 32'h55);
    rdreg(12'h004, rd, rv); check("R11 value ro", rd, 32'hFFFF_FFFE);
    wr(12'h010, 32'h1);
    rdreg(12'h010, rd, rv); check("R11 raw ro", rd, 0);
    rdreg(12'h00C, rd, rv); check("R11 clr reads 0", rd, 0);
    rdreg(12'hF04, rd, rv); check("R11 tout reads 0", rd, 0);
    rdreg(12'h100, rd, rv); check("R11 unmapped", rd, 0);
    wr(12'hFE0, 32'h99);
    rdreg(12'hFE0, rd, rv); check("R11 id fe0", rd, 32'h21);
    rdreg(12'hFF0, rd, rv); check("R11 id ff0", rd, 32'h0D);

    // R4 lock
    wr(12'hC00, 32'h5);
    rdreg(12'hC00, rd, rv); check("R4 locked", rd, 1);
    wr(12'h000, 32'h7);
    rdreg(12'h000, rd, rv); check("R4 load dropped", rd, 32'hFFFF_FFFF);
    wr(12'h008, 32'h0);
    rdreg(12'h008, rd, rv); check("R4 ctrl dropped", rd, 32'h3);
    wr(12'hC00, 32'h1ACC_E551);
    rdreg(12'hC00, rd, rv); check("R4 unlocked", rd, 0);
    wr(12'h000, 32'h7);
    rdreg(12'h000, rd, rv); check("R5 load stored", rd, 32'h7);
    rdreg(12'h004, rd, rv); check("R5 counter loaded", rd, 32'h7);

    // R6/R7 sweep of load values
    for (int L = 1; L <= 8; L++) begin
      do_reset();
      wr(12'h008, 32'h3);
      wr(12'h000, 32'(L));
      n = 0;
      while (!irq && n < 100) begin tick1(); n++; end
      check($sformatf("R6 first expiry L=%0d", L), 32'(n), 32'(L));
      check("R6 no reset yet", {31'b0, rreq}, 0);
      rdreg(12'h010, rd, rv); check("R6 raw set", rd, 1);
      while (!rreq && n < 100) begin tick1(); n++; end
      check($sformatf("R7 second expiry L=%0d", L), 32'(n), 32'(2*L+1));
      rdreg(12'h004, rd, rv); check("R7 stopped at 0", rd, 0);
      repeat (3) tick1();
      rdreg(12'h004, rd, rv); check("R7 stays 0", rd, 0);
    end

    // R9 control sweep with raw and reset status both set
    for (int c = 0; c < 4; c++) begin
      wr(12'h008, 32'(c));
      check($sformatf("R9 irq c=%0d", c), {31'b0, irq}, 32'(c & 1));
      check($sformatf("R9 rst c=%0d", c), {31'b0, rreq}, 32'((c >> 1) & 1));
      rdreg(12'h014, rd, rv); check("R9 masked", rd, 32'(c & 1));
    end

    // R10 test mode sweep (ctrl=0, so normal path is low)
    wr(12'h008, 32'h0);
    wr(12'hF00, 32'h1);
    for (int v = 0; v < 4; v++) begin
      wr(12'hF04, 32'(v));
      check($sformatf("R10 irq v=%0d", v), {31'b0, irq}, 32'((v >> 1) & 1));
      check($sformatf("R10 rst v=%0d", v), {31'b0, rreq}, 32'(v & 1));
    end
    wr(12'hF00, 32'h0);
    check("R10 test off", {30'b0, irq, rreq}, 0);

    // R8 servicing and R5 restart
    do_reset();
    wr(12'h008, 32'h3);
    wr(12'h000, 32'd4);
    repeat (4) tick1();
    check("R8 irq before clear", {31'b0, irq}, 1);
    tick1();
    wr(12'h00C, 32'h0);
    check("R8 irq cleared", {31'b0, irq}, 0);
    rdreg(12'h004, rd, rv); check("R8 reloaded", rd, 32'd4);
    repeat (4) tick1();
    check("R8 irq again", {31'b0, irq}, 1);
    check("R8 no reset", {31'b0, rreq}, 0);
    // tick in the same cycle as a clear: clear wins
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = 12'h00C; penable = 0;
    @(negedge clk);
    penable = 1; tick_en = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; tick_en = 0;
    rdreg(12'h004, rd, rv); check("R8 clear beats tick", rd, 32'd4);

    // R12 sticky variant
    do_reset();
    wr(12'h008, 32'h1);
    wr(12'h008, 32'h2);
    rdreg(12'h008, rd, rv);
    check("R12 sticky ctrl", rv, 32'h1);
    check("R12 plain ctrl", rd, 32'h2);
    wr(12'hF00, 32'h1);
    wr(12'hF04, 32'h3);
    check("R12 test ignored", {30'b0, irq_v, rreq_v}, 0);
    rdreg(12'hF00, rd, rv); check("R12 tctl unmapped", rv, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule